// File: doc/BRIEF.md
# Task-Routed Result Return Switch

This block carries finished results from a set of shared co-processors back to the master processors that asked for them. Each co-processor presents one result at a time, tagged with the number of the task that issued the instruction. A task-to-master table, driven from outside, says which master is running each task at this moment. The switch looks the tag up in the table and steers the result to that master.

The masters accept a result in every cycle and match it to a pending instruction by its task number. Because of that, the switch never holds off its outputs. Any waiting happens on the co-processor side. A co-processor keeps its valid, tag and data steady until it sees its grant.

When several co-processors want the same master, the one that has waited longest goes first. There are no priorities. Requests that arrived in the same cycle go in ascending co-processor index. A result whose task is not mapped to any master waits in place until the table assigns the task.

Top module: `rrs_switch`

## Requirements
- R1: While `rst_n` is low, every bit of `mst_valid` is low. All waiting times restart from zero after reset.
- R2: A result granted in cycle t appears in cycle t+1 on the master that the table named for its task in cycle t. Its task id and data reach that master unchanged.
- R3: A mapped request is granted in the same cycle its valid is first seen if no other request for the same master is older than it or shares its age with a lower index.
- R4: A request whose task has its `task_map_en` bit low is not granted and stays waiting. It is granted in the first cycle after the task is mapped in which it wins the arbitration for its master. The table is read per task t: enable at `task_map_en[t]`, master index in binary at `task_map_id[t*MID_W +: MID_W]`. An index of `N_MST` or above matches no master.
- R5: Requests for one master whose valid first rose in the same cycle are granted in ascending co-processor index, one per cycle.
- R6: For a given master, a request that arrived in an earlier cycle is granted before one that arrived later, whatever their indices.
- R7: Requests for different masters are granted in the same cycle. Each master receives at most one grant per cycle.
- R8: In the cycle after a master received no grant, its `mst_valid` bit is low.
- R9: `cop_grant[i]` is high only while `cop_valid[i]` is high. Co-processor i's fields sit at `cop_task[i*TID_W +: TID_W]` and `cop_data[i*DATA_W +: DATA_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cop_valid | input | N_COP | Co-processor i holds a result |
| cop_task | input | N_COP*TID_W | Task tag of each co-processor's result |
| cop_data | input | N_COP*DATA_W | Result data of each co-processor |
| cop_grant | output | N_COP | Result of co-processor i taken this cycle (combinational) |
| task_map_en | input | N_TASK | Task t is currently placed on a master |
| task_map_id | input | N_TASK*MID_W | Master index per task |
| mst_valid | output | N_MST | Result delivered to master m this cycle |
| mst_task | output | N_MST*TID_W | Task tag of the delivered result |
| mst_data | output | N_MST*DATA_W | Data of the delivered result |

## Verification
Grants are combinational, so the bench samples `cop_grant` one nanosecond after it drives a new set of inputs at the falling edge. The delivered result is registered, so the bench checks `mst_valid`, `mst_task` and `mst_data` one nanosecond after the next rising edge, against the expectation it recorded from its own grant prediction. The bench tracks the arrival cycle of each request itself, so its oldest-first ordering does not depend on any counter inside the design. It removes a request from its model only after that rising edge.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  // Index width that stays at least one bit for single-entry sets.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rrs_age_track.sv
module rrs_age_track #(
  parameter int unsigned AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             grant,
  output logic [AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [AGE_W-1:0] age_q;
  logic [AGE_W-1:0] age_d;

  // A waiting request grows older; a taken or absent one starts over.
  always_comb begin
    age_d = '0;
    if (req && !grant) begin
      age_d = (age_q == AGE_MAX) ? AGE_MAX : age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else begin
      age_q <= age_d;
    end
  end

  assign age = age_q;
endmodule

// File: rtl/rrs_dest_lookup.sv
module rrs_dest_lookup #(
  parameter int unsigned N_TASK = 8,
  parameter int unsigned N_MST  = 2,
  parameter int unsigned TID_W  = 3,
  parameter int unsigned MID_W  = 1
) (
  input  logic                    valid,
  input  logic [TID_W-1:0]        task_id,
  input  logic [N_TASK-1:0]       map_en,
  input  logic [N_TASK*MID_W-1:0] map_id,
  output logic [N_MST-1:0]        hit
);
  // Tables padded to the full tag range so every tag indexes safely.
  localparam int unsigned TSPAN = 1 << TID_W;

  logic [TSPAN-1:0]       en_ext;
  logic [TSPAN*MID_W-1:0] id_ext;
  logic                   sel_en;
  logic [MID_W-1:0]       sel_id;

  assign en_ext = TSPAN'(map_en);
  assign id_ext = (TSPAN*MID_W)'(map_id);
  assign sel_en = en_ext[task_id];
  assign sel_id = id_ext[task_id*MID_W +: MID_W];

  for (genvar m = 0; m < N_MST; m++) begin : g_hit
    assign hit[m] = valid && sel_en && (sel_id == MID_W'(m));
  end
endmodule

// File: rtl/rrs_arbiter.sv
module rrs_arbiter #(
  parameter int unsigned N_COP = 4,
  parameter int unsigned AGE_W = 8
) (
  input  logic [N_COP-1:0]       req,
  input  logic [N_COP*AGE_W-1:0] age,
  output logic [N_COP-1:0]       gnt
);
  logic             found;
  logic [AGE_W-1:0] best_age;

  // Oldest wins; a strict compare keeps the lowest index on a tie.
  always_comb begin
    gnt      = '0;
    found    = 1'b0;
    best_age = '0;
    for (int i = 0; i < N_COP; i++) begin
      if (req[i] && (!found || (age[i*AGE_W +: AGE_W] > best_age))) begin
        found    = 1'b1;
        best_age = age[i*AGE_W +: AGE_W];
        gnt      = '0;
        gnt[i]   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rrs_switch.sv
module rrs_switch #(
  parameter int unsigned N_COP  = 4,
  parameter int unsigned N_MST  = 2,
  parameter int unsigned N_TASK = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AGE_W  = 8,
  parameter int unsigned TID_W  = rrs_pkg::idx_w(N_TASK),
  parameter int unsigned MID_W  = rrs_pkg::idx_w(N_MST)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_COP-1:0]        cop_valid,
  input  logic [N_COP*TID_W-1:0]  cop_task,
  input  logic [N_COP*DATA_W-1:0] cop_data,
  output logic [N_COP-1:0]        cop_grant,
  input  logic [N_TASK-1:0]       task_map_en,
  input  logic [N_TASK*MID_W-1:0] task_map_id,
  output logic [N_MST-1:0]        mst_valid,
  output logic [N_MST*TID_W-1:0]  mst_task,
  output logic [N_MST*DATA_W-1:0] mst_data
);
  logic [N_MST-1:0]       hit_by_cop [N_COP];
  logic [N_COP-1:0]       req_by_mst [N_MST];
  logic [N_COP-1:0]       gnt_by_mst [N_MST];
  logic [N_COP*AGE_W-1:0] age_flat;

  // Per co-processor: destination decode and waiting time.
  for (genvar i = 0; i < N_COP; i++) begin : g_cop
    rrs_dest_lookup #(
      .N_TASK (N_TASK),
      .N_MST  (N_MST),
      .TID_W  (TID_W),
      .MID_W  (MID_W)
    ) u_lookup (
      .valid   (cop_valid[i]),
      .task_id (cop_task[i*TID_W +: TID_W]),
      .map_en  (task_map_en),
      .map_id  (task_map_id),
      .hit     (hit_by_cop[i])
    );

    rrs_age_track #(
      .AGE_W (AGE_W)
    ) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (cop_valid[i]),
      .grant (cop_grant[i]),
      .age   (age_flat[i*AGE_W +: AGE_W])
    );
  end

  // Per master: gather requests, arbitrate, select, register.
  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    logic              vld_d;
    logic [TID_W-1:0]  tid_d;
    logic [DATA_W-1:0] dat_d;
    logic              vld_q;
    logic [TID_W-1:0]  tid_q;
    logic [DATA_W-1:0] dat_q;

    always_comb begin
      for (int i = 0; i < N_COP; i++) begin
        req_by_mst[m][i] = hit_by_cop[i][m];
      end
    end

    rrs_arbiter #(
      .N_COP (N_COP),
      .AGE_W (AGE_W)
    ) u_arb (
      .req (req_by_mst[m]),
      .age (age_flat),
      .gnt (gnt_by_mst[m])
    );

    always_comb begin
      vld_d = |gnt_by_mst[m];
      tid_d = '0;
      dat_d = '0;
      for (int i = 0; i < N_COP; i++) begin
        tid_d = tid_d | ({TID_W{gnt_by_mst[m][i]}}  & cop_task[i*TID_W +: TID_W]);
        dat_d = dat_d | ({DATA_W{gnt_by_mst[m][i]}} & cop_data[i*DATA_W +: DATA_W]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
      end
    end

    // Payload registers load only with a grant; their value counts only with vld_q.
    always_ff @(posedge clk) begin
      if (vld_d) begin
        tid_q <= tid_d;
        dat_q <= dat_d;
      end
    end

    assign mst_valid[m]                 = vld_q;
    assign mst_task[m*TID_W +: TID_W]   = tid_q;
    assign mst_data[m*DATA_W +: DATA_W] = dat_q;
  end

  // A co-processor is taken if any master's arbiter picked it.
  always_comb begin
    cop_grant = '0;
    for (int m = 0; m < N_MST; m++) begin
      cop_grant = cop_grant | gnt_by_mst[m];
    end
  end
endmodule

// File: rtl/rrs_switch_chk.sv
module rrs_switch_chk #(
  parameter int unsigned N_COP = 4,
  parameter int unsigned N_MST = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_COP-1:0] cop_valid,
  input logic [N_COP-1:0] cop_grant,
  input logic [N_MST-1:0] mst_valid
);
  // R9: only a present result can be taken.
  p_grant_has_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_grant & ~cop_valid) == '0);

  // R7: no more grants than masters in any cycle.
  p_grant_per_mst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cop_grant) <= N_MST);

  // R2: any grant produces a delivery in the next cycle.
  p_grant_delivers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_grant != '0) |=> (mst_valid != '0));

  // R8: deliveries in a cycle equal the grants of the cycle before.
  p_delivery_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(mst_valid) == $past($countones(cop_grant))));
endmodule

bind rrs_switch rrs_switch_chk #(
  .N_COP (N_COP),
  .N_MST (N_MST)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cop_valid (cop_valid),
  .cop_grant (cop_grant),
  .mst_valid (mst_valid)
);

// File: tb/sim_rrs_switch.sv
`timescale 1ns/1ps
module sim_rrs_switch;
  localparam int NC = 4;
  localparam int NM = 2;
  localparam int NT = 8;
  localparam int DW = 16;
  localparam int TW = 3;
  localparam int MW = 1;

  logic            clk;
  logic            rst_n;
  logic [NC-1:0]   cop_valid;
  logic [NC*TW-1:0] cop_task;
  logic [NC*DW-1:0] cop_data;
  logic [NC-1:0]   cop_grant;
  logic [NT-1:0]   task_map_en;
  logic [NT*MW-1:0] task_map_id;
  logic [NM-1:0]   mst_valid;
  logic [NM*TW-1:0] mst_task;
  logic [NM*DW-1:0] mst_data;

  rrs_switch u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cop_valid   (cop_valid),
    .cop_task    (cop_task),
    .cop_data    (cop_data),
    .cop_grant   (cop_grant),
    .task_map_en (task_map_en),
    .task_map_id (task_map_id),
    .mst_valid   (mst_valid),
    .mst_task    (mst_task),
    .mst_data    (mst_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycle  = 0;
  bit done   = 0;

  // Bench model of the co-processor side and the mapping table.
  bit          pend  [NC];
  logic [2:0]  ptask [NC];
  logic [15:0] pdata [NC];
  int          parr  [NC];
  bit          men   [NT];
  bit          mid   [NT];

  bit          ev [NM];
  logic [2:0]  et [NM];
  logic [15:0] ed [NM];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  function automatic logic [NC-1:0] exp_grant();
    logic [NC-1:0] g = '0;
    for (int m = 0; m < NM; m++) begin
      int best = -1;
      for (int i = 0; i < NC; i++) begin
        if (pend[i] && men[ptask[i]] && (int'(mid[ptask[i]]) == m)) begin
          if (best < 0 || parr[i] < parr[best]) best = i;
        end
      end
      ev[m] = (best >= 0);
      if (best >= 0) begin
        g[best] = 1'b1;
        et[m]   = ptask[best];
        ed[m]   = pdata[best];
      end
    end
    return g;
  endfunction

  task automatic drive();
    for (int i = 0; i < NC; i++) begin
      cop_valid[i]          = pend[i];
      cop_task[i*TW +: TW]  = ptask[i];
      cop_data[i*DW +: DW]  = pdata[i];
    end
    for (int t = 0; t < NT; t++) begin
      task_map_en[t] = men[t];
      task_map_id[t] = mid[t];
    end
  endtask

  task automatic post(input int i, input int tk, input int d);
    pend[i]  = 1'b1;
    ptask[i] = 3'(tk);
    pdata[i] = 16'(d);
    parr[i]  = cycle;
  endtask

  // One cycle: drive, check grant, check delivery, retire granted requests.
  task automatic step(input string greq);
    logic [NC-1:0] eg;
    @(negedge clk);
    drive();
    #1;
    eg = exp_grant();
    check(cop_grant == eg, greq, cop_grant, eg);
    @(posedge clk);
    #1;
    for (int m = 0; m < NM; m++) begin
      check(mst_valid[m] == ev[m], ev[m] ? "R2" : "R8", mst_valid[m], ev[m]);
      if (ev[m]) begin
        check(mst_task[m*TW +: TW] == et[m], "R2", mst_task[m*TW +: TW], et[m]);
        check(mst_data[m*DW +: DW] == ed[m], "R2", mst_data[m*DW +: DW], ed[m]);
      end
    end
    for (int i = 0; i < NC; i++) if (eg[i]) pend[i] = 1'b0;
    cycle++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NC; i++) begin pend[i] = 0; ptask[i] = 0; pdata[i] = 0; parr[i] = 0; end
    for (int t = 0; t < NT; t++) begin men[t] = 1; mid[t] = t[0]; end
    rst_n = 1'b0;
    drive();
    repeat (3) @(posedge clk);
    #1;
    check(mst_valid == '0, "R1", mst_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(mst_valid == '0, "R1", mst_valid, 0);

    // R2 and R3: single uncontested result, routed by its task.
    mid[2] = 1'b1;
    post(0, 2, 16'hA5A5);
    step("R3");

    // R5: four same-cycle arrivals for master 0, ascending index.
    mid[1] = 0; mid[3] = 0;
    post(0, 1, 16'h1000); post(1, 3, 16'h1001);
    post(2, 1, 16'h1002); post(3, 3, 16'h1003);
    for (int k = 0; k < 4; k++) step("R5");

    // R6: older cop3 beats newer cop1.
    post(0, 1, 16'h2000); post(3, 1, 16'h2003);
    step("R6");
    post(1, 3, 16'h2001);
    step("R6");
    check(pend[3] == 1'b0 && pend[1] == 1'b1, "R6", {pend[3], pend[1]}, 2'b01);
    step("R6");

    // R4: unmapped task waits, then goes once mapped.
    men[5] = 1'b0;
    post(2, 5, 16'h5555);
    for (int k = 0; k < 4; k++) begin
      step("R4");
      check(pend[2] == 1'b1, "R4", pend[2], 1);
    end
    men[5] = 1'b1; mid[5] = 1'b1;
    step("R4");
    check(pend[2] == 1'b0, "R4", pend[2], 0);

    // R7: two masters served in one cycle.
    mid[0] = 0; mid[4] = 1;
    post(1, 0, 16'h7070); post(2, 4, 16'h7171);
    step("R7");

    // R9 and R8: nothing pending, no grant, no delivery.
    step("R9");

    // Random traffic with changing mapping.
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 15) == 0) begin
        int t = $urandom_range(0, NT - 1);
        men[t] = $urandom_range(0, 2) != 0;
        mid[t] = $urandom_range(0, 1) != 0;
      end
      for (int t = 0; t < NT; t++) begin
        if (!men[t] && $urandom_range(0, 7) == 0) men[t] = 1'b1;
      end
      for (int i = 0; i < NC; i++) begin
        if (!pend[i] && $urandom_range(0, 1) == 1) post(i, $urandom_range(0, NT - 1), $urandom_range(0, 65535));
      end
      step("R6");
    end

    finish_run();
  end
endmodule